// File: doc/BRIEF.md
# Open-Row DRAM Burst Read Controller

This block accepts read requests from a processor-side port and turns each one into the strobe sequence that a DRAM with a shared, multiplexed address bus expects. A flat 22-bit word address is cut into an 11-bit row (the upper bits) and an 11-bit column (the lower bits). Both halves go out one after the other on one 11-bit address bus. The row goes out under a row strobe and the column under a column strobe.

The controller keeps the last selected row open. A later request to that same row skips the close and row-select steps and goes straight to column strobes. Each request is served as a four-word burst, which is the size of a cache line. After one row selection, four column strobes go out on consecutive cycles and the column steps by one for each word. The first word comes back 7 cycles after acceptance on a row hit and 9 cycles after on a row miss. The other three words follow one cycle apart. A one-cycle status pulse tells which of the two cases occurred.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and pre_stb, row_stb, col_stb, rd_valid, hit_pls and miss_pls are all 0.
- R2: The row is req_addr[21:11] and the column is req_addr[10:0]. mem_addr carries the row in every cycle in which row_stb is 1, and it carries a column in every cycle in which col_stb is 1. row_stb and col_stb are never 1 together.
- R3: A request is accepted on a rising edge where req_valid and req_ready are both 1. That request is a row hit only if a row is open and the stored row equals the new row. Otherwise it is a row miss, and the first request after reset is always a miss. In the cycle right after acceptance (cycle 0), exactly one of hit_pls and miss_pls is 1, and both are 0 in every other cycle.
- R4: On a miss, pre_stb is 1 in cycle 2 only, and only if a row was open. row_stb is 1 in cycle 4 only. The new row then becomes the open row.
- R5: On a hit, pre_stb and row_stb stay 0, and col_stb is 1 in cycles 4 to 7.
- R6: On a miss, col_stb is 1 in cycles 6 to 9. Over the four strobes, mem_addr carries col, col+1, col+2 and col+3, each taken modulo 2048.
- R7: For each column strobe cycle t, rd_valid is 1 in cycle t+3, and rd_data there equals the mem_rdata of cycle t+2. This gives words in cycles 7 to 10 on a hit and 9 to 12 on a miss. rd_last marks the fourth word only.
- R8: req_ready is 0 from cycle 0 until the final word. It is 1 again in the cycle of the final word. A req_valid raised while req_ready is 0 is ignored: it produces no pulse and no strobes, and it does not change the open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 22 | Word address of the request |
| req_ready | output | 1 | Controller can accept a request |
| mem_addr | output | 11 | Multiplexed row/column address to the DRAM |
| pre_stb | output | 1 | Close (precharge) the open row |
| row_stb | output | 1 | Row select strobe |
| col_stb | output | 1 | Column select strobe |
| mem_rdata | input | 64 | Read data from the DRAM |
| rd_valid | output | 1 | A burst word is present on rd_data |
| rd_data | output | 64 | Burst word returned to the requester |
| rd_last | output | 1 | Fourth word of the burst |
| hit_pls | output | 1 | The accepted request hit the open row |
| miss_pls | output | 1 | The accepted request missed the open row |

## Verification
Several request streams are used, and each one separates a different pair of cases:
- The first access after reset, followed by an access to the same row, separates the miss path with no close from the hit path.
- A change of row after a row has been opened checks that the close strobe is present.
- Columns near 2047 separate correct modulo stepping from a carry that leaks into the row field.
- A random mix of same-row and new-row requests, driven back to back, checks hit tracking across many accepts.
- A request raised while the controller is busy must leave no trace.

A model of the device in the bench returns data tagged by row and column, so any error in the data path or in column order shows up directly.

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 64,
  parameter int BURST  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  output logic                     req_ready,
  output logic [COL_W-1:0]         mem_addr,
  output logic                     pre_stb,
  output logic                     row_stb,
  output logic                     col_stb,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_last,
  output logic                     hit_pls,
  output logic                     miss_pls
);
  localparam int ADDR_W   = ROW_W + COL_W;
  localparam int CNT_W    = 5;
  localparam int PRE_AT   = 2;
  localparam int ROW_AT   = 4;
  localparam int HIT_COL  = 4;
  localparam int MISS_COL = 6;
  localparam int RET_LAT  = 3;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] cur_row, open_row;
  logic [COL_W-1:0] cur_col;
  logic             cur_hit, cur_pre, row_open;
  logic             p1_v, p2_v, p1_l, p2_l;

  wire accept  = req_valid && !busy;
  wire req_hit = row_open && (open_row == req_addr[ADDR_W-1:COL_W]);

  wire [CNT_W-1:0] col_base = cur_hit ? CNT_W'(HIT_COL) : CNT_W'(MISS_COL);
  wire [CNT_W-1:0] last_cnt = col_base + CNT_W'(BURST - 1 + RET_LAT);
  wire [CNT_W-1:0] beat     = cnt - col_base;
  wire             in_col   = busy && cnt >= col_base && cnt < col_base + CNT_W'(BURST);

  assign req_ready = !busy;
  assign col_stb   = in_col;
  assign row_stb   = busy && !cur_hit && cnt == CNT_W'(ROW_AT);
  assign pre_stb   = busy && !cur_hit && cur_pre && cnt == CNT_W'(PRE_AT);
  assign mem_addr  = row_stb ? cur_row : in_col ? cur_col + COL_W'(beat) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      row_open <= 1'b0;
      open_row <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
      cur_hit  <= 1'b0;
      cur_pre  <= 1'b0;
      hit_pls  <= 1'b0;
      miss_pls <= 1'b0;
    end else begin
      hit_pls  <= accept && req_hit;
      miss_pls <= accept && !req_hit;
      if (accept) begin
        busy     <= 1'b1;
        cnt      <= '0;
        cur_row  <= req_addr[ADDR_W-1:COL_W];
        cur_col  <= req_addr[COL_W-1:0];
        cur_hit  <= req_hit;
        cur_pre  <= row_open;
        open_row <= req_addr[ADDR_W-1:COL_W];
        row_open <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == last_cnt - 1'b1) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_v <= 1'b0; p2_v <= 1'b0; p1_l <= 1'b0; p2_l <= 1'b0;
      rd_valid <= 1'b0; rd_last <= 1'b0; rd_data <= '0;
    end else begin
      p1_v     <= in_col;
      p1_l     <= in_col && beat == CNT_W'(BURST - 1);
      p2_v     <= p1_v;
      p2_l     <= p1_l;
      rd_valid <= p2_v;
      rd_last  <= p2_l;
      if (p2_v) rd_data <= mem_rdata;
    end
  end

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_stb && col_stb));
  assert_status_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_pls, miss_pls}));
  assert_row_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |=> !row_stb && !col_stb);
  assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && $past(col_stb)) |-> mem_addr == COL_W'($past(mem_addr) + 1'b1));
  assert_last_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |-> !req_ready);
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/dram_page_ctrl_bench.sv
module dram_page_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [21:0] req_addr = '0;
  logic        req_ready, pre_stb, row_stb, col_stb, rd_valid, rd_last, hit_pls, miss_pls;
  logic [10:0] mem_addr;
  logic [63:0] mem_rdata, rd_data;

  int total = 0, bad = 0;
  bit finished = 0;
  bit bopen = 0;
  logic [10:0] brow = '0;

  always #4 clk = ~clk;

  dram_page_ctrl u_dram_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .mem_addr(mem_addr), .pre_stb(pre_stb),
    .row_stb(row_stb), .col_stb(col_stb), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .hit_pls(hit_pls), .miss_pls(miss_pls));

  function automatic logic [63:0] dat(input logic [10:0] r, input logic [10:0] c);
    return {21'h15A5A5, r, 21'h0C3C3C, c};
  endfunction

  logic [10:0] dev_row = '0;
  logic [63:0] d1 = '0, d2 = '0;
  always @(posedge clk) begin
    if (row_stb) dev_row <= mem_addr;
    d1 <= col_stb ? dat(dev_row, mem_addr) : 64'h0;
    d2 <= d1;
  end
  assign mem_rdata = d2;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_req(input logic [21:0] a, input bit poke_busy);
    logic [10:0] r = a[21:11];
    logic [10:0] c = a[10:0];
    bit hit = bopen && brow == r;
    bit was_open = bopen;
    int cs = hit ? 4 : 6;
    int last = cs + 6;
    chk(req_ready == 1'b1, "R8 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    bopen = 1; brow = r;
    for (int i = 0; i <= last; i++) begin
      if (i > 0) @(negedge clk);
      if (poke_busy && i == 3) begin req_valid = 1'b1; req_addr = ~a; end
      if (poke_busy && i == 5) req_valid = 1'b0;
      chk(hit_pls == (i == 0 && hit), "R3 hit pulse", hit_pls, (i == 0 && hit));
      chk(miss_pls == (i == 0 && !hit), "R3 miss pulse", miss_pls, (i == 0 && !hit));
      chk(pre_stb == (!hit && was_open && i == 2), "R4 precharge", pre_stb, (!hit && was_open && i == 2));
      chk(row_stb == (!hit && i == 4), "R4 row strobe", row_stb, (!hit && i == 4));
      if (row_stb) chk(mem_addr == r, "R2 row on bus", mem_addr, r);
      chk(col_stb == (i >= cs && i < cs + 4), hit ? "R5 col strobe" : "R6 col strobe",
          col_stb, (i >= cs && i < cs + 4));
      if (i >= cs && i < cs + 4)
        chk(mem_addr == 11'(c + 11'(i - cs)), "R6 column step", mem_addr, 11'(c + 11'(i - cs)));
      chk(rd_valid == (i >= cs + 3 && i < cs + 7), "R7 data valid", rd_valid, (i >= cs + 3 && i < cs + 7));
      if (i >= cs + 3 && i < cs + 7) begin
        chk(rd_data == dat(r, 11'(c + 11'(i - cs - 3))), "R7 data word", rd_data, dat(r, 11'(c + 11'(i - cs - 3))));
        chk(rd_last == (i == cs + 6), "R7 last flag", rd_last, (i == cs + 6));
      end
      chk(req_ready == (i == last), "R8 ready timing", req_ready, (i == last));
    end
  endtask

  initial begin
    #200_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(req_ready && !pre_stb && !row_stb && !col_stb && !rd_valid && !hit_pls && !miss_pls,
        "R1 reset state", {req_ready, pre_stb, row_stb, col_stb, rd_valid, hit_pls, miss_pls}, 7'b1000000);
    do_req({11'd5, 11'd100}, 0);
    do_req({11'd5, 11'd2046}, 0);
    do_req({11'd9, 11'd2047}, 1);
    do_req({11'd9, 11'd0}, 0);
    do_req({11'h7FF, 11'd2045}, 0);
    for (int k = 0; k < 40; k++) begin
      logic [10:0] r = ($urandom % 2) ? brow : 11'($urandom);
      logic [10:0] c = ($urandom % 4 == 0) ? 11'(2044 + $urandom % 4) : 11'($urandom);
      do_req({r, c}, (k % 7) == 3);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule